// File: doc/BRIEF.md
# Commutative-Update Privatizing Cache

A small direct-mapped data cache that lets a core privatize lines and apply commutative additions to them without creating extra copies in memory. The first commutative add to a line reads the line from memory. The cache keeps an untouched snapshot of it in a small fully associative source buffer and marks the cached line as private. Later adds to that line change only the cached copy. Memory sees none of this work until the core issues a merge. The merge walks every private line and writes back memory + (updated − source), word by word. The result keeps both the private updates and any changes another agent made to memory in the meantime.

Ordinary loads and stores share the same single-request port. Loads are cached as clean lines. Stores write through with a line read-modify-write. A line-invalidate input from the outside world can drop clean lines but never touches private ones. The memory side is a one-request-at-a-time line port with an acknowledge.

Request op codes are 0 load, 1 store, 2 commutative add, 3 merge. Response codes are 0 OK, 1 error, 2 stall. Addresses are word addresses; the line address is addr[AW-1:2], the word offset is addr[1:0], and the cache index is the line address modulo 8.

Top module: `cup_cache`

## Requirements
- R1: After reset, req_ready is high, rsp_valid and mem_req are low, and no line is private.
- R2: A load to a line that is not private returns the word with code 0. A miss reads the line from memory and caches it clean, unless its index holds a private line. A hit on a clean line returns the cached word without any memory request.
- R3: A store to a line that is not private writes the word to memory with code 0 and rsp_data 0. The other words of that line are unchanged. A clean cached copy of the line is refreshed with the whole written line.
- R4: The first commutative add to a line reads the line once, snapshots it into a free source entry, and makes the cached copy the word plus the operand. It responds code 0 with the new word value and performs no memory write.
- R5: A commutative add to a line that is already private updates the cached word and returns its new value, with no memory request of any kind.
- R6: A load or store to a private line responds code 1 with rsp_data 0. It makes no memory request and changes nothing.
- R7: A first commutative add responds code 2 (stall) with no memory request and no state change in either of two cases: all 4 source entries are in use, or its index already holds a private line of another tag.
- R8: A merge writes memory + (updated − source) modulo 2^32 for every word of every private line. It then responds code 0, the lines become clean copies of the merged data, and their source entries are free again.
- R9: A line-invalidate drops a matching clean line, so the next load reads memory again. It has no effect on a private line.
- R10: Memory changes made by another agent between the first touch and the merge survive in the merged result.
- R11: A merge with no private lines responds code 0 without any memory request.
- R12: Once mem_req is raised it stays high, with line, write flag and write data stable, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block idle; request taken at this edge |
| req_op | input | 2 | 0 load, 1 store, 2 commutative add, 3 merge |
| req_addr | input | AW | Word address |
| req_data | input | DW | Store data or add operand |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_code | output | 2 | 0 OK, 1 error, 2 stall |
| rsp_data | output | DW | Load word or updated word |
| snoop_valid | input | 1 | Line-invalidate request |
| snoop_line | input | AW-2 | Line address to invalidate |
| mem_req | output | 1 | Memory request held until ack |
| mem_we | output | 1 | 1 write line, 0 read line |
| mem_line | output | AW-2 | Memory line address |
| mem_wdata | output | WORDS*DW | Line write data |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | WORDS*DW | Line read data, valid with ack |

## Verification
The main function is tried with several patterns. Repeated adds to one word, and adds spread over words of one line, show whether the cached copy accumulates without touching memory. Filling all four source entries, and aiming at an occupied index, separates the full-buffer stall from the conflict stall. A merge after another agent has changed memory tells a three-way merge apart from a plain writeback, because a writeback would lose that change. A long pseudo-random mix of loads, stores, adds, merges and invalidates over two tags per index checks the block against a behavioural model every clock, including memory quietness on hits and stable memory requests.

// File: rtl/cup_pkg.sv
package cup_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_CADD  = 2'd2,
        OP_MERGE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_ERR   = 2'd1,
        RSP_STALL = 2'd2
    } rsp_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RD    = 3'd1,
        S_WR    = 3'd2,
        S_MSCAN = 3'd3,
        S_MRD   = 3'd4,
        S_MWR   = 3'd5
    } state_e;
endpackage

// File: rtl/cup_line_patch.sv
module cup_line_patch #(
    parameter int DW    = 32,
    parameter int WORDS = 4
) (
    input  logic [WORDS*DW-1:0]         base_line,
    input  logic [$clog2(WORDS)-1:0]    sel,
    input  logic [DW-1:0]               operand,
    input  logic                        add_mode,
    output logic [WORDS*DW-1:0]         out_line
);
    localparam int OFFW = $clog2(WORDS);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DW-1:0] cur;
        assign cur = base_line[w*DW +: DW];
        assign out_line[w*DW +: DW] = (sel == OFFW'(w)) ?
                                      (add_mode ? cur + operand : operand) : cur;
    end
endmodule

// File: rtl/cup_merge_alu.sv
module cup_merge_alu #(
    parameter int DW    = 32,
    parameter int WORDS = 4
) (
    input  logic [WORDS*DW-1:0] mem_line,
    input  logic [WORDS*DW-1:0] src_line,
    input  logic [WORDS*DW-1:0] upd_line,
    output logic [WORDS*DW-1:0] merged_line
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DW-1:0] delta;
        assign delta = upd_line[w*DW +: DW] - src_line[w*DW +: DW];
        assign merged_line[w*DW +: DW] = mem_line[w*DW +: DW] + delta;
    end
endmodule

// File: rtl/cup_srcbuf.sv
module cup_srcbuf #(
    parameter int LW   = 128,
    parameter int NSRC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_en,
    input  logic [LW-1:0]             alloc_data,
    output logic [$clog2(NSRC)-1:0]   alloc_idx,
    output logic                      has_free,
    input  logic                      free_en,
    input  logic [$clog2(NSRC)-1:0]   free_idx,
    input  logic [$clog2(NSRC)-1:0]   rd_idx,
    output logic [LW-1:0]             rd_data,
    output logic [NSRC-1:0]           valid_vec
);
    localparam int PW = $clog2(NSRC);

    typedef struct packed {
        logic [NSRC-1:0]         valid;
        logic [NSRC-1:0][LW-1:0] data;
    } sb_t;

    sb_t s_q, s_d;

    always_comb begin
        alloc_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (!s_q.valid[i]) alloc_idx = PW'(i);
        end
    end

    assign has_free  = ~&s_q.valid;
    assign rd_data   = s_q.data[rd_idx];
    assign valid_vec = s_q.valid;

    always_comb begin
        s_d = s_q;
        if (free_en) s_d.valid[free_idx] = 1'b0;
        if (alloc_en) begin
            s_d.valid[alloc_idx] = 1'b1;
            s_d.data[alloc_idx]  = alloc_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_alloc_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> has_free)
        else $error("snapshot taken with no free entry");

    assert_free_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> s_q.valid[free_idx])
        else $error("release of an unused entry");

    assert_alloc_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !free_en) |=> ($countones(s_q.valid) == $countones($past(s_q.valid)) + 1))
        else $error("snapshot did not occupy an entry");
endmodule

// File: rtl/cup_cache.sv
module cup_cache
    import cup_pkg::*;
#(
    parameter int AW     = 10,
    parameter int DW     = 32,
    parameter int WORDS  = 4,
    parameter int NLINES = 8,
    parameter int NSRC   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [1:0]                        req_op,
    input  logic [AW-1:0]                     req_addr,
    input  logic [DW-1:0]                     req_data,
    output logic                              rsp_valid,
    output logic [1:0]                        rsp_code,
    output logic [DW-1:0]                     rsp_data,
    input  logic                              snoop_valid,
    input  logic [AW-$clog2(WORDS)-1:0]       snoop_line,
    output logic                              mem_req,
    output logic                              mem_we,
    output logic [AW-$clog2(WORDS)-1:0]       mem_line,
    output logic [WORDS*DW-1:0]               mem_wdata,
    input  logic                              mem_ack,
    input  logic [WORDS*DW-1:0]               mem_rdata
);
    localparam int OFFW = $clog2(WORDS);
    localparam int IDXW = $clog2(NLINES);
    localparam int LAW  = AW - OFFW;
    localparam int TAGW = LAW - IDXW;
    localparam int PW   = $clog2(NSRC);
    localparam int LW   = WORDS * DW;

    typedef struct packed {
        state_e                      state;
        op_e                         op;
        logic [AW-1:0]               addr;
        logic [DW-1:0]               data;
        logic                        rsp_valid;
        rsp_e                        rsp_code;
        logic [DW-1:0]               rsp_data;
        logic                        mem_req;
        logic                        mem_we;
        logic [LAW-1:0]              mem_line;
        logic [LW-1:0]               mem_wdata;
        logic [IDXW-1:0]             scan;
        logic [NLINES-1:0]           valid;
        logic [NLINES-1:0]           cdata;
        logic [NLINES-1:0][TAGW-1:0] tag;
        logic [NLINES-1:0][PW-1:0]   ptr;
        logic [NLINES-1:0][LW-1:0]   line;
    } st_t;

    st_t q, n;

    function automatic logic [DW-1:0] word_of(input logic [LW-1:0] l, input logic [OFFW-1:0] o);
        return l[DW*int'(o) +: DW];
    endfunction

    // address fields of the incoming, latched and snoop addresses
    logic [OFFW-1:0] r_off, l_off;
    logic [IDXW-1:0] r_idx, l_idx, s_idx;
    logic [TAGW-1:0] r_tag, l_tag, s_tag;
    logic            r_hit, r_priv, r_block, l_hit;

    assign r_off = req_addr[OFFW-1:0];
    assign r_idx = req_addr[OFFW +: IDXW];
    assign r_tag = req_addr[AW-1:OFFW+IDXW];
    assign l_off = q.addr[OFFW-1:0];
    assign l_idx = q.addr[OFFW +: IDXW];
    assign l_tag = q.addr[AW-1:OFFW+IDXW];
    assign s_idx = snoop_line[IDXW-1:0];
    assign s_tag = snoop_line[LAW-1:IDXW];

    assign r_hit   = q.valid[r_idx] && (q.tag[r_idx] == r_tag);
    assign r_priv  = r_hit && q.cdata[r_idx];
    assign r_block = q.cdata[r_idx] && (q.tag[r_idx] != r_tag);
    assign l_hit   = q.valid[l_idx] && (q.tag[l_idx] == l_tag);

    // word patch: add on the cached copy while idle, else on the fetched line
    logic [LW-1:0]   pt_base, pt_out;
    logic [OFFW-1:0] pt_sel;
    logic [DW-1:0]   pt_opnd;
    logic            pt_add;

    always_comb begin
        if (q.state == S_IDLE) begin
            pt_base = q.line[r_idx];
            pt_sel  = r_off;
            pt_opnd = req_data;
            pt_add  = 1'b1;
        end else begin
            pt_base = mem_rdata;
            pt_sel  = l_off;
            pt_opnd = q.data;
            pt_add  = (q.op == OP_CADD);
        end
    end

    cup_line_patch #(.DW(DW), .WORDS(WORDS)) u_patch (
        .base_line (pt_base),
        .sel       (pt_sel),
        .operand   (pt_opnd),
        .add_mode  (pt_add),
        .out_line  (pt_out)
    );

    logic            sb_alloc_en, sb_free_en, sb_has_free;
    logic [PW-1:0]   sb_alloc_idx;
    logic [LW-1:0]   sb_rd_data;
    logic [NSRC-1:0] sb_valid;

    cup_srcbuf #(.LW(LW), .NSRC(NSRC)) u_srcbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (sb_alloc_en),
        .alloc_data (mem_rdata),
        .alloc_idx  (sb_alloc_idx),
        .has_free   (sb_has_free),
        .free_en    (sb_free_en),
        .free_idx   (q.ptr[q.scan]),
        .rd_idx     (q.ptr[q.scan]),
        .rd_data    (sb_rd_data),
        .valid_vec  (sb_valid)
    );

    logic [LW-1:0] merged;

    cup_merge_alu #(.DW(DW), .WORDS(WORDS)) u_merge (
        .mem_line    (mem_rdata),
        .src_line    (sb_rd_data),
        .upd_line    (q.line[q.scan]),
        .merged_line (merged)
    );

    always_comb begin
        n           = q;
        n.rsp_valid = 1'b0;
        sb_alloc_en = 1'b0;
        sb_free_en  = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (req_valid) begin
                    n.op   = op_e'(req_op);
                    n.addr = req_addr;
                    n.data = req_data;
                    n.rsp_data = '0;
                    unique case (op_e'(req_op))
                        OP_LOAD, OP_STORE: begin
                            if (r_priv) begin
                                n.rsp_valid = 1'b1;
                                n.rsp_code  = RSP_ERR;
                            end else if (op_e'(req_op) == OP_LOAD && r_hit) begin
                                n.rsp_valid = 1'b1;
                                n.rsp_code  = RSP_OK;
                                n.rsp_data  = word_of(q.line[r_idx], r_off);
                            end else begin
                                n.mem_req  = 1'b1;
                                n.mem_we   = 1'b0;
                                n.mem_line = req_addr[AW-1:OFFW];
                                n.state    = S_RD;
                            end
                        end
                        OP_CADD: begin
                            if (r_priv) begin
                                n.line[r_idx] = pt_out;
                                n.rsp_valid   = 1'b1;
                                n.rsp_code    = RSP_OK;
                                n.rsp_data    = word_of(pt_out, r_off);
                            end else if (r_block || !sb_has_free) begin
                                n.rsp_valid = 1'b1;
                                n.rsp_code  = RSP_STALL;
                            end else begin
                                n.mem_req  = 1'b1;
                                n.mem_we   = 1'b0;
                                n.mem_line = req_addr[AW-1:OFFW];
                                n.state    = S_RD;
                            end
                        end
                        default: begin
                            n.scan  = '0;
                            n.state = S_MSCAN;
                        end
                    endcase
                end
            end
            S_RD: begin
                if (mem_ack) begin
                    n.mem_req = 1'b0;
                    unique case (q.op)
                        OP_LOAD: begin
                            n.rsp_valid = 1'b1;
                            n.rsp_code  = RSP_OK;
                            n.rsp_data  = word_of(mem_rdata, l_off);
                            if (!q.cdata[l_idx]) begin
                                n.valid[l_idx] = 1'b1;
                                n.tag[l_idx]   = l_tag;
                                n.line[l_idx]  = mem_rdata;
                            end
                            n.state = S_IDLE;
                        end
                        OP_STORE: begin
                            n.mem_req   = 1'b1;
                            n.mem_we    = 1'b1;
                            n.mem_wdata = pt_out;
                            if (l_hit) n.line[l_idx] = pt_out;
                            n.state = S_WR;
                        end
                        OP_CADD: begin
                            sb_alloc_en    = 1'b1;
                            n.line[l_idx]  = pt_out;
                            n.valid[l_idx] = 1'b1;
                            n.cdata[l_idx] = 1'b1;
                            n.tag[l_idx]   = l_tag;
                            n.ptr[l_idx]   = sb_alloc_idx;
                            n.rsp_valid    = 1'b1;
                            n.rsp_code     = RSP_OK;
                            n.rsp_data     = word_of(pt_out, l_off);
                            n.state        = S_IDLE;
                        end
                        default: n.state = S_IDLE;
                    endcase
                end
            end
            S_WR: begin
                if (mem_ack) begin
                    n.mem_req   = 1'b0;
                    n.mem_we    = 1'b0;
                    n.rsp_valid = 1'b1;
                    n.rsp_code  = RSP_OK;
                    n.state     = S_IDLE;
                end
            end
            S_MSCAN: begin
                if (q.cdata[q.scan]) begin
                    n.mem_req  = 1'b1;
                    n.mem_we   = 1'b0;
                    n.mem_line = {q.tag[q.scan], q.scan};
                    n.state    = S_MRD;
                end else if (q.scan == IDXW'(NLINES - 1)) begin
                    n.rsp_valid = 1'b1;
                    n.rsp_code  = RSP_OK;
                    n.state     = S_IDLE;
                end else begin
                    n.scan = q.scan + 1'b1;
                end
            end
            S_MRD: begin
                if (mem_ack) begin
                    n.mem_we       = 1'b1;
                    n.mem_wdata    = merged;
                    n.line[q.scan] = merged;
                    n.state        = S_MWR;
                end
            end
            S_MWR: begin
                if (mem_ack) begin
                    n.mem_req       = 1'b0;
                    n.mem_we        = 1'b0;
                    n.cdata[q.scan] = 1'b0;
                    sb_free_en      = 1'b1;
                    n.state         = S_MSCAN;
                end
            end
            default: n.state = S_IDLE;
        endcase
        // external invalidate: clean lines only, private lines are exempt
        if (snoop_valid && q.valid[s_idx] && (q.tag[s_idx] == s_tag) && !q.cdata[s_idx])
            n.valid[s_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign req_ready = (q.state == S_IDLE);
    assign rsp_valid = q.rsp_valid;
    assign rsp_code  = q.rsp_code;
    assign rsp_data  = q.rsp_data;
    assign mem_req   = q.mem_req;
    assign mem_we    = q.mem_we;
    assign mem_line  = q.mem_line;
    assign mem_wdata = q.mem_wdata;

    assert_snap_tracks_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.cdata) == $countones(sb_valid))
        else $error("private lines and used snapshots disagree");

    assert_cadd_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (q.op != OP_CADD))
        else $error("memory written during a commutative add");

    assert_err_only_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_ERR) |-> (q.op == OP_LOAD || q.op == OP_STORE))
        else $error("error response on a non load/store op");

    assert_merge_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q.op == OP_MERGE) |-> (q.cdata == '0 && sb_valid == '0))
        else $error("merge finished with private lines left");

    assert_snoop_spares_priv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && q.cdata[s_idx] && q.tag[s_idx] == s_tag && q.state != S_MWR)
        |=> q.cdata[$past(s_idx)])
        else $error("invalidate removed a private line");

    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line) && $stable(mem_we) && $stable(mem_wdata)))
        else $error("memory request changed before ack");
endmodule

// File: tb/tb_cup_cache.sv
`timescale 1ns/1ps
module tb_cup_cache;
    localparam int AW = 10, DW = 32, WORDS = 4, NLINES = 8, NSRC = 4;
    localparam int LAW = AW - 2;
    localparam int NL = 1 << LAW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic rsp_valid;
    logic [1:0] rsp_code;
    logic [DW-1:0] rsp_data;
    logic snoop_valid = 1'b0;
    logic [LAW-1:0] snoop_line = '0;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [LAW-1:0] mem_line;
    logic [WORDS*DW-1:0] mem_wdata, mem_rdata = '0;

    always #5 clk = ~clk;

    cup_cache #(.AW(AW), .DW(DW), .WORDS(WORDS), .NLINES(NLINES), .NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
        .snoop_valid(snoop_valid), .snoop_line(snoop_line),
        .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    int errors = 0, checks = 0;
    bit finished = 0;

    // backing memory driven by the responder, and the model's expectation of it
    logic [DW-1:0] mem [NL*WORDS];
    logic [DW-1:0] exp_mem [NL*WORDS];
    // behavioural model state
    bit            priv_v [NL];
    logic [DW-1:0] priv_src [NL][WORDS];
    logic [DW-1:0] priv_upd [NL][WORDS];
    bit            priv_at [NLINES];
    int            npriv = 0;
    bit            clean_v [NLINES];
    int            clean_tag [NLINES];
    logic [DW-1:0] clean_d [NLINES][WORDS];

    bit pending = 0, quiet = 0;
    string quiet_tag = "";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder: fixed latency of two sampling cycles
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && rst_n) begin
                lat++;
                if (lat == 2) begin
                    lat = 0;
                    mem_ack = 1'b1;
                    for (int w = 0; w < WORDS; w++) begin
                        if (mem_we) mem[int'(mem_line)*WORDS + w] = mem_wdata[w*DW +: DW];
                        mem_rdata[w*DW +: DW] = mem[int'(mem_line)*WORDS + w];
                    end
                end
            end else lat = 0;
        end
    end

    // per-clock comparison of port behaviour against the model's expectations
    initial begin
        bit p_req = 0, p_ack = 0, p_we = 0;
        logic [LAW-1:0] p_line = '0;
        logic [WORDS*DW-1:0] p_wd = '0;
        forever begin
            @(negedge clk); #1;
            if (rst_n) begin
                if (rsp_valid && !pending)
                    chk(0, "R2", "response with no request", 32'(rsp_valid), 0);
                if (quiet && mem_req)
                    chk(0, quiet_tag, "memory touched by a cache-only op", 32'(mem_req), 0);
                if (p_req && !p_ack)
                    chk(mem_req && mem_line == p_line && mem_we == p_we && mem_wdata == p_wd,
                        "R12", "request not held", 32'(mem_line), 32'(p_line));
                p_req = mem_req; p_ack = mem_ack; p_line = mem_line; p_we = mem_we; p_wd = mem_wdata;
            end
        end
    end

    task automatic model_op(input int op, input int addr, input logic [DW-1:0] d,
                            output int code, output logic [DW-1:0] rd, output bit q_only);
        int ln = addr / WORDS, off = addr % WORDS, idx = ln % NLINES, tg = ln / NLINES;
        code = 0; rd = '0; q_only = 0;
        case (op)
            0: begin
                if (priv_v[ln]) begin code = 1; q_only = 1; end
                else if (clean_v[idx] && clean_tag[idx] == tg) begin rd = clean_d[idx][off]; q_only = 1; end
                else begin
                    rd = exp_mem[addr];
                    if (!priv_at[idx]) begin
                        clean_v[idx] = 1; clean_tag[idx] = tg;
                        for (int w = 0; w < WORDS; w++) clean_d[idx][w] = exp_mem[ln*WORDS + w];
                    end
                end
            end
            1: begin
                if (priv_v[ln]) begin code = 1; q_only = 1; end
                else begin
                    exp_mem[addr] = d;
                    if (clean_v[idx] && clean_tag[idx] == tg)
                        for (int w = 0; w < WORDS; w++) clean_d[idx][w] = exp_mem[ln*WORDS + w];
                end
            end
            2: begin
                if (priv_v[ln]) begin
                    priv_upd[ln][off] += d; rd = priv_upd[ln][off]; q_only = 1;
                end else if (priv_at[idx] || npriv == NSRC) begin
                    code = 2; q_only = 1;
                end else begin
                    for (int w = 0; w < WORDS; w++) begin
                        priv_src[ln][w] = exp_mem[ln*WORDS + w];
                        priv_upd[ln][w] = exp_mem[ln*WORDS + w];
                    end
                    priv_upd[ln][off] += d; rd = priv_upd[ln][off];
                    priv_v[ln] = 1; priv_at[idx] = 1; npriv++; clean_v[idx] = 0;
                end
            end
            default: begin
                q_only = (npriv == 0);
                for (int l = 0; l < NL; l++) begin
                    if (priv_v[l]) begin
                        for (int w = 0; w < WORDS; w++) begin
                            exp_mem[l*WORDS + w] += priv_upd[l][w] - priv_src[l][w];
                            clean_d[l % NLINES][w] = exp_mem[l*WORDS + w];
                        end
                        clean_v[l % NLINES] = 1; clean_tag[l % NLINES] = l / NLINES;
                        priv_v[l] = 0; priv_at[l % NLINES] = 0;
                    end
                end
                npriv = 0;
            end
        endcase
    endtask

    task automatic do_op(input int op, input int addr, input logic [DW-1:0] d, input string req);
        int code; logic [DW-1:0] rd; bit q_only; int guard = 0;
        model_op(op, addr, d, code, rd, q_only);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(addr); req_data = d;
        pending = 1; quiet = q_only; quiet_tag = req;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
        chk(rsp_valid && rsp_code == 2'(code), req, $sformatf("op %0d @%h code", op, addr),
            32'(rsp_code), 32'(code));
        chk(rsp_data == rd, req, $sformatf("op %0d @%h data", op, addr), rsp_data, rd);
        @(posedge clk);
        pending = 0; quiet = 0;
    endtask

    task automatic do_snoop(input int ln);
        int idx = ln % NLINES;
        if (clean_v[idx] && clean_tag[idx] == ln / NLINES && !priv_at[idx]) clean_v[idx] = 0;
        @(negedge clk);
        snoop_valid = 1'b1; snoop_line = LAW'(ln);
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    task automatic poke(input int addr, input logic [DW-1:0] v);
        mem[addr] = v; exp_mem[addr] = v;
    endtask

    task automatic check_mem(input int addr, input string req);
        chk(mem[addr] === exp_mem[addr], req, $sformatf("memory @%h", addr), mem[addr], exp_mem[addr]);
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int bad = 0;
        for (int i = 0; i < NL*WORDS; i++) begin
            mem[i] = 32'(i) * 32'h01000193 + 32'h11;
            exp_mem[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        chk(rsp_valid == 0 && mem_req == 0, "R1", "outputs in reset", {30'b0, rsp_valid, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_ready == 1 && rsp_valid == 0 && mem_req == 0, "R1", "idle after reset",
            {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

        do_op(0, 'h010, 0, "R2");            // miss
        do_op(0, 'h012, 0, "R2");            // clean hit, quiet
        do_op(1, 'h011, 32'hDEAD_BEEF, "R3");
        check_mem('h011, "R3"); check_mem('h010, "R3"); check_mem('h013, "R3");
        do_op(0, 'h011, 0, "R3");            // refreshed clean copy

        do_op(2, 'h040, 32'd5, "R4");        // first touch
        check_mem('h040, "R4");
        do_op(2, 'h041, 32'd7, "R5");
        do_op(2, 'h040, 32'hFFFF_FFFF, "R5");  // wraps
        check_mem('h041, "R5");
        do_op(0, 'h040, 0, "R6");
        do_op(1, 'h042, 32'h1234, "R6");
        check_mem('h042, "R6");

        do_op(2, 'h060, 32'd1, "R7");        // same index, other tag
        do_op(2, 'h044, 32'd2, "R4");
        do_op(2, 'h048, 32'd3, "R4");
        do_op(2, 'h04C, 32'd4, "R4");
        do_op(2, 'h050, 32'd9, "R7");        // buffer full

        poke('h041, mem['h041] + 32'd100);   // another agent, R10
        do_snoop('h040 / WORDS);             // private line, R9
        do_op(3, 0, 0, "R8");
        for (int a = 'h040; a < 'h050; a++) check_mem(a, "R8");
        check_mem('h041, "R10");
        do_op(2, 'h050, 32'd9, "R8");        // entries free again
        do_op(0, 'h040, 0, "R8");
        do_op(3, 0, 0, "R8");
        do_op(3, 0, 0, "R11");               // nothing private

        do_op(0, 'h0A0, 0, "R9");
        poke('h0A0, 32'hCAFE_0001);
        do_op(0, 'h0A0, 0, "R9");            // stale clean copy
        do_snoop('h0A0 / WORDS);
        do_op(0, 'h0A0, 0, "R9");            // reloaded

        for (int k = 0; k < 400; k++) begin
            int op, addr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            addr = 'h100 + ((int'(lfsr) >> 3) % 16) * WORDS + ((int'(lfsr) >> 7) & 3);
            case (lfsr % 8)
                0, 1: op = 0;
                2: op = 1;
                3, 4, 5: op = 2;
                6: op = 3;
                default: op = 4;
            endcase
            if (op == 4) do_snoop(addr / WORDS);
            else do_op(op, addr, {lfsr, lfsr ^ 16'h5A5A}, op == 2 ? "R5" : (op == 3 ? "R8" : "R2"));
        end
        do_op(3, 0, 0, "R8");
        for (int i = 0; i < NL*WORDS; i++) if (mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, "R8", "final memory mismatches", 32'(bad), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule